// File: doc/BRIEF.md
# DMA Global Run Control with Latched Emergency Stop

This block is the global run-control register of a multi-channel DMA engine. It holds a master run bit and a sticky emergency-stop flag. It combines them with the enable of each channel to produce one transfer-permit line per channel. An edge on the emergency (non-maskable interrupt) input sets the flag. Once the flag is set, no channel may start a new transfer unit. A channel that is partway through a unit keeps its permit until that unit reports completion.

Software reaches the register through a simple strobe interface. The run bit can be read and written freely. The flag is cleared by reading it as 1 and then writing 0 to it. A read that lands in the same cycle as the emergency input returns the old value 0, yet still arms the clear. Any emergency event after the arming read cancels the pending clear. This includes an event in the cycle of the write itself.

Top module: `dma_gctl`

## Requirements
- R1: After reset the run bit (register bit 0) and the stop flag (register bit 1) are 0. All permit outputs are 0. A read returns 0.
- R2: A write loads bit 0 of the write data into the run bit. A read returns the run bit at bit 0 in the same cycle as the read strobe.
- R3: When the flag is clear, permit for channel c equals the run bit AND the enable of channel c, with no cycle of delay.
- R4: With the emergency input high at a clock edge, the flag is 1 after that edge, whether the run bit is 0 or 1.
- R5: A channel that accepted a start before the flag was set keeps its permit until its done pulse. Its permit is 0 from the edge that takes that pulse. While the flag is 1, a start on an idle channel is not accepted.
- R6: Writing 1 to bit 1 leaves the flag unchanged.
- R7: Writing 0 to bit 1 without an earlier read that armed the clear leaves the flag at 1.
- R8: A read that returns the flag as 1, followed by a write with bit 1 at 0, clears the flag. The clear also cancels the armed state.
- R9: A read in the same cycle as the emergency input returns bit 1 as 0. It still arms the clear, so a following write of 0 clears the flag.
- R10: An emergency event after the arming read, including one in the cycle of the clearing write, cancels the armed state and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Emergency-stop event, one cycle per event |
| acc_re_i | input | 1 | Register read strobe |
| acc_we_i | input | 1 | Register write strobe |
| acc_wdata_i | input | REG_W | Write data: bit 0 run, bit 1 flag |
| acc_rdata_o | output | REG_W | Read data, valid while acc_re_i is high |
| ch_en_i | input | NCH | Per-channel enable |
| unit_start_i | input | NCH | Channel begins a transfer unit |
| unit_done_i | input | NCH | Channel finished its transfer unit |
| permit_o | output | NCH | Per-channel transfer permit |

## Verification
Two events can coincide: a register read and the emergency input setting the flag. A second pair is the clearing write and a fresh emergency event. The bench raises the read strobe and the emergency input in the same cycle. It then checks that bit 1 of the read data is 0, and that a later write of 0 releases the channel permits. It also pulses the emergency input between the read and the write, and in the write cycle itself. In both cases it checks that the permits stay low, which shows the flag survived.

// File: rtl/dma_gctl_pkg.sv
package dma_gctl_pkg;
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned FLAG_BIT = 1;
  localparam int unsigned REG_W    = FLAG_BIT + 1;
endpackage

// File: rtl/dma_gctl_flag.sv
module dma_gctl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_flag_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, arm_q, flag_d, arm_d, clr;

  // the event wins over a clear in the same cycle
  assign clr = wr_i & ~wr_flag_i & arm_q & ~nmi_i;

  always_comb begin
    flag_d = flag_q;
    if (nmi_i)    flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  // a read racing the set edge arms as though 1 were returned
  always_comb begin
    arm_d = arm_q;
    if (clr)        arm_d = 1'b0;
    else if (rd_i)  arm_d = flag_q | nmi_i;
    else if (nmi_i) arm_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;
endmodule

// File: rtl/dma_gctl_chan.sv
module dma_gctl_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic flag_i,
  input  logic ch_en_i,
  input  logic start_i,
  input  logic done_i,
  output logic permit_o,
  output logic in_unit_o
);
  logic in_unit_q, start_ok;

  assign start_ok = start_i & run_i & ch_en_i & ~flag_i & ~in_unit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       in_unit_q <= 1'b0;
    else if (start_ok) in_unit_q <= 1'b1;
    else if (done_i)   in_unit_q <= 1'b0;
  end

  assign permit_o  = run_i & ch_en_i & (~flag_i | in_unit_q);
  assign in_unit_o = in_unit_q;
endmodule

// File: rtl/dma_gctl.sv
module dma_gctl
  import dma_gctl_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             acc_re_i,
  input  logic             acc_we_i,
  input  logic [REG_W-1:0] acc_wdata_i,
  output logic [REG_W-1:0] acc_rdata_o,
  input  logic [NCH-1:0]   ch_en_i,
  input  logic [NCH-1:0]   unit_start_i,
  input  logic [NCH-1:0]   unit_done_i,
  output logic [NCH-1:0]   permit_o
);
  logic run_q, flag, armed;
  logic [NCH-1:0] in_unit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= 1'b0;
    else if (acc_we_i) run_q <= acc_wdata_i[RUN_BIT];
  end

  dma_gctl_flag i_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nmi_i    (nmi_i),
    .rd_i     (acc_re_i),
    .wr_i     (acc_we_i),
    .wr_flag_i(acc_wdata_i[FLAG_BIT]),
    .flag_o   (flag),
    .armed_o  (armed)
  );

  always_comb begin
    acc_rdata_o = '0;
    if (acc_re_i) begin
      acc_rdata_o[RUN_BIT]  = run_q;
      acc_rdata_o[FLAG_BIT] = flag;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_gctl_chan i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q),
      .flag_i   (flag),
      .ch_en_i  (ch_en_i[c]),
      .start_i  (unit_start_i[c]),
      .done_i   (unit_done_i[c]),
      .permit_o (permit_o[c]),
      .in_unit_o(in_unit[c])
    );
  end
endmodule

// File: rtl/dma_gctl_chk.sv
module dma_gctl_chk
  import dma_gctl_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nmi_i,
  input logic             acc_re_i,
  input logic             acc_we_i,
  input logic [REG_W-1:0] acc_wdata_i,
  input logic [REG_W-1:0] acc_rdata_o,
  input logic [NCH-1:0]   ch_en_i,
  input logic [NCH-1:0]   permit_o,
  input logic             run_q,
  input logic             flag,
  input logic             armed,
  input logic [NCH-1:0]   in_unit
);
  p_run_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_i |=> run_q == $past(acc_wdata_i[RUN_BIT]));

  p_flag_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag |-> (permit_o & ~in_unit) == '0);

  p_nmi_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> flag);

  p_unit_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_unit & ch_en_i & {NCH{run_q}} & ~permit_o) == '0);

  p_wr1_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && acc_we_i && acc_wdata_i[FLAG_BIT]) |=> flag);

  p_unarmed_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && acc_we_i && !armed) |=> flag);

  p_race_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_re_i && nmi_i && !flag) |-> (acc_rdata_o[FLAG_BIT] == 1'b0) ##1 armed);

  p_nmi_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !acc_re_i) |=> !armed);
endmodule

bind dma_gctl dma_gctl_chk #(.NCH(NCH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nmi_i      (nmi_i),
  .acc_re_i   (acc_re_i),
  .acc_we_i   (acc_we_i),
  .acc_wdata_i(acc_wdata_i),
  .acc_rdata_o(acc_rdata_o),
  .ch_en_i    (ch_en_i),
  .permit_o   (permit_o),
  .run_q      (run_q),
  .flag       (flag),
  .armed      (armed),
  .in_unit    (in_unit)
);

// File: tb/test_dma_gctl.sv
module test_dma_gctl;
  localparam int unsigned NCH = 4;
  localparam int unsigned RW  = 2;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0, nmi = 1'b0, re = 1'b0, we = 1'b0;
  logic [RW-1:0]  wdata = '0;
  logic [RW-1:0]  rdata;
  logic [NCH-1:0] ch_en = '0, start = '0, done = '0, permit;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_gctl #(.NCH(NCH)) i_dma_gctl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .acc_re_i(re), .acc_we_i(we),
    .acc_wdata_i(wdata), .acc_rdata_o(rdata), .ch_en_i(ch_en),
    .unit_start_i(start), .unit_done_i(done), .permit_o(permit)
  );

  // {run, ch_en, expected permit} with the flag clear
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 4'hF, 4'h0}, {1'b1, 4'hF, 4'hF}, {1'b1, 4'h5, 4'h5},
    {1'b1, 4'h0, 4'h0}, {1'b0, 4'hA, 4'h0}, {1'b1, 4'h8, 4'h8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [RW-1:0] d, input logic with_nmi = 1'b0);
    we = 1'b1; wdata = d; nmi = with_nmi;
    @(posedge clk); @(negedge clk);
    we = 1'b0; nmi = 1'b0;
  endtask

  task automatic reg_rd(output logic [RW-1:0] d);
    re = 1'b1; #2; d = rdata;
    @(posedge clk); @(negedge clk);
    re = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi = 1'b1;
    @(posedge clk); @(negedge clk);
    nmi = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] rd;
    #5; @(negedge clk);
    re = 1'b1; #2;
    chk("R1 rdata", rdata, 0);
    chk("R1 permit", permit, 0);
    re = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    re = 1'b1; #2;
    chk("R1 rdata after release", rdata, 0);
    re = 1'b0;

    reg_wr(2'b11); reg_rd(rd); chk("R2 run=1", rd[0], 1);
    reg_wr(2'b10); reg_rd(rd); chk("R2 run=0", rd[0], 0);

    foreach (VEC[i]) begin
      reg_wr({1'b1, VEC[i][8]});
      ch_en = VEC[i][7:4]; #2;
      chk("R3 permit", permit, VEC[i][3:0]);
    end

    // flag set while the run bit is 0
    reg_wr(2'b10); ch_en = 4'b0011;
    nmi_pulse();
    reg_rd(rd); chk("R4 flag set while stopped", rd[1], 1);
    reg_wr(2'b01); #2;
    chk("R8 read-1 then write-0 clears", permit, 4'b0011);

    nmi_pulse(); reg_rd(rd);
    reg_wr(2'b11); #2;
    chk("R6 write-1 keeps flag", permit, 0);
    reg_wr(2'b01); #2;
    chk("R8 clear after write-1", permit, 4'b0011);

    nmi_pulse();
    reg_wr(2'b01); #2;
    chk("R7 unarmed write-0 keeps flag", permit, 0);
    reg_rd(rd); reg_wr(2'b01);

    // read in the cycle the flag is set
    re = 1'b1; nmi = 1'b1; #2;
    chk("R9 racing read returns 0", rdata[1], 0);
    @(posedge clk); @(negedge clk);
    re = 1'b0; nmi = 1'b0; #2;
    chk("R9 flag set", permit, 0);
    reg_wr(2'b01); #2;
    chk("R9 write-0 clears after racing read", permit, 4'b0011);

    nmi_pulse(); reg_rd(rd); nmi_pulse();
    reg_wr(2'b01); #2;
    chk("R10 event between read and write", permit, 0);
    reg_rd(rd); reg_wr(2'b01);

    nmi_pulse(); reg_rd(rd);
    reg_wr(2'b01, 1'b1); #2;
    chk("R10 event in write cycle", permit, 0);
    reg_rd(rd); reg_wr(2'b01); #2;
    chk("R8 clear restores permits", permit, 4'b0011);

    // unit in flight when the event arrives
    start = 4'b0001; @(posedge clk); @(negedge clk); start = '0;
    nmi_pulse(); #2;
    chk("R5 unit in flight keeps permit", permit, 4'b0001);
    start = 4'b0010; @(posedge clk); @(negedge clk); start = '0; #2;
    chk("R5 start refused while flagged", permit, 4'b0001);
    done = 4'b0001; @(posedge clk); @(negedge clk); done = '0; #2;
    chk("R5 permit drops after done", permit, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule